// File: doc/BRIEF.md
# Package Idle-State Resolver

This block merges the idle-state reports of a configurable number of cores, four by default, into a single low-power state for the whole package. Each core reports a 3-bit state code. A per-core enable masks out cores that are parked or fused off. Three platform inputs complete the picture: a general permission for low-power entry, an indication that the deepest state is allowed, and a grant of a request for that deepest state.

The package follows the shallowest enabled core. Any shallow core, or a missing platform permission, holds the package in C0. The deepest package state, C6, is reached only when every enabled core sits in C6 and the platform has both allowed and granted it. When the platform withholds C6, the package settles in C3 instead.

The resolved state is registered. It is accompanied by a registered flag that tells whether the shared last-level cache still holds valid contents. A one-cycle strobe marks every cycle in which the state output takes a new value.

Top module: `pkg_idle_resolver`

## Requirements
- R1: Under synchronous active-low reset, the package state output is C0 (code 0), the cache-valid output is 1 and the change strobe is 0, including when reset is applied from a deep state.
- R2: State codes are 3 bits wide, on both inputs and outputs: C0=0, C1=1, C1E=2, C3=3, C6=4. An enabled core reporting any other code (5, 6 or 7) is treated as C0.
- R3: When any enabled core reports C0, the package state is C0 one clock edge later.
- R4: When the low-power permission input is 0, the package state is C0 one clock edge later, whatever the cores report.
- R5: With permission given, the package state one edge later equals the shallowest (lowest-coded) state among the enabled cores when that state is C1, C1E or C3.
- R6: When every enabled core reports C6 and permission is given, the package enters C6 only if the deep-allow and deep-grant inputs are both 1. Otherwise it resolves to C3.
- R7: A core whose enable bit (bit i of the enable vector for core i, which occupies bits 3i+2..3i of the state vector) is 0 counts as C6 regardless of its code. With all cores disabled, R6 applies.
- R8: The cache-valid output is 0 exactly when the package state output is C6, and 1 in every other state.
- R9: The change strobe is 1 for exactly the cycle in which the package state output differs from its value in the previous cycle, and 0 while the state holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_state_i | input | NUM_CORES*3 | Per-core state codes, core i in bits 3i+2..3i |
| core_en_i | input | NUM_CORES | Per-core enable; 0 masks the core as C6 |
| lp_grant_i | input | 1 | Platform permission for any package low-power state |
| deep_allow_i | input | 1 | Platform allows the deepest package state |
| deep_grant_i | input | 1 | Platform grants the request for the deepest state |
| pkg_state_o | output | 3 | Resolved package state code |
| cache_valid_o | output | 1 | Shared last-level cache contents are valid |
| state_chg_o | output | 1 | One-cycle pulse when the package state changes |

## Verification
The cores are given uniform states, mixed states where the shallowest core differs from the rest, and mixes that contain a single C0 core. Together these separate a true minimum from a maximum or a majority rule, and confirm that one awake core overrides all others.

All-C6 patterns are repeated under each combination of the three platform inputs. This shows that C6 needs all three inputs and that C3 is the fallback when the deep inputs are missing, while C0 results whenever permission itself is absent.

Masked cores that report C0, and unused codes on enabled cores, show that masking and code sanitising act in opposite directions. Repeated identical vectors and a reset taken from C6 exercise the strobe and the reset values.

// File: rtl/pkg_idle_pkg.sv
// Shared types for the package idle-state resolver.
// Assumes a 3-bit state code that is shared by core reports and the package output.
package pkg_idle_pkg;
    localparam int CS_W = 3;

    typedef enum logic [CS_W-1:0] {
        CS_C0  = 3'd0,
        CS_C1  = 3'd1,
        CS_C1E = 3'd2,
        CS_C3  = 3'd3,
        CS_C6  = 3'd4
    } cstate_e;
endpackage

// File: rtl/pir_core_filter.sv
// Sanitises each core report: disabled cores become C6, unknown codes become C0.
// Assumes core i occupies bits CS_W*i +: CS_W of the flat vectors.
module pir_core_filter
    import pkg_idle_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic [NUM_CORES*CS_W-1:0] raw_i,
    input  logic [NUM_CORES-1:0]      en_i,
    output logic [NUM_CORES*CS_W-1:0] eff_o
);
    for (genvar gi = 0; gi < NUM_CORES; gi++) begin : g_core
        logic [CS_W-1:0] code;
        assign code = raw_i[gi*CS_W +: CS_W];

        // Per-core mask and code clean-up.
        always_comb begin
            if (!en_i[gi]) begin
                eff_o[gi*CS_W +: CS_W] = CS_C6;
            end else if (code > CS_C6) begin
                eff_o[gi*CS_W +: CS_W] = CS_C0;
            end else begin
                eff_o[gi*CS_W +: CS_W] = code;
            end
        end
    end
endmodule

// File: rtl/pir_min_reduce.sv
// Finds the shallowest (lowest-coded) state among the filtered core states.
// Assumes its inputs were sanitised to legal codes, so the result is a legal state.
module pir_min_reduce
    import pkg_idle_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic [NUM_CORES*CS_W-1:0] eff_i,
    output cstate_e                   min_o
);
    // Linear minimum scan seeded with the deepest state.
    always_comb begin
        logic [CS_W-1:0] m;
        m = CS_C6;
        for (int i = 0; i < NUM_CORES; i++) begin
            if (eff_i[i*CS_W +: CS_W] < m) begin
                m = eff_i[i*CS_W +: CS_W];
            end
        end
        min_o = cstate_e'(m);
    end
endmodule

// File: rtl/pir_policy.sv
// Applies the platform permissions to the core-derived request.
// Assumes req_i is a legal state; it produces the next package state.
module pir_policy
    import pkg_idle_pkg::*;
(
    input  cstate_e req_i,
    input  logic    lp_grant_i,
    input  logic    deep_allow_i,
    input  logic    deep_grant_i,
    output cstate_e next_o
);
    // Permission gating and fallback from C6 to C3.
    always_comb begin
        if (!lp_grant_i) begin
            next_o = CS_C0;
        end else if (req_i == CS_C6 && !(deep_allow_i && deep_grant_i)) begin
            next_o = CS_C3;
        end else begin
            next_o = req_i;
        end
    end
endmodule

// File: rtl/pkg_idle_resolver.sv
// Top of the package idle-state resolver: filter, minimum, policy, output register.
// Assumes all inputs are synchronous to clk; reset is synchronous and active low.
module pkg_idle_resolver
    import pkg_idle_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CORES*CS_W-1:0] core_state_i,
    input  logic [NUM_CORES-1:0]      core_en_i,
    input  logic                      lp_grant_i,
    input  logic                      deep_allow_i,
    input  logic                      deep_grant_i,
    output logic [CS_W-1:0]           pkg_state_o,
    output logic                      cache_valid_o,
    output logic                      state_chg_o
);
    logic [NUM_CORES*CS_W-1:0] eff;
    cstate_e                   req;
    cstate_e                   nxt;
    cstate_e                   state_q;
    logic                      cache_q;
    logic                      chg_q;

    pir_core_filter #(.NUM_CORES(NUM_CORES)) filter_i (
        .raw_i (core_state_i),
        .en_i  (core_en_i),
        .eff_o (eff)
    );

    pir_min_reduce #(.NUM_CORES(NUM_CORES)) reduce_i (
        .eff_i (eff),
        .min_o (req)
    );

    pir_policy policy_i (
        .req_i        (req),
        .lp_grant_i   (lp_grant_i),
        .deep_allow_i (deep_allow_i),
        .deep_grant_i (deep_grant_i),
        .next_o       (nxt)
    );

    // Output register: state, cache flag and change strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CS_C0;
            cache_q <= 1'b1;
            chg_q   <= 1'b0;
        end else begin
            state_q <= nxt;
            cache_q <= (nxt != CS_C6);
            chg_q   <= (nxt != state_q);
        end
    end

    assign pkg_state_o   = state_q;
    assign cache_valid_o = cache_q;
    assign state_chg_o   = chg_q;

    // Independent view of "some enabled core is awake", taken from raw inputs.
    logic chk_awake;
    always_comb begin
        chk_awake = 1'b0;
        for (int i = 0; i < NUM_CORES; i++) begin
            if (core_en_i[i] && (core_state_i[i*CS_W +: CS_W] == 3'd0)) begin
                chk_awake = 1'b1;
            end
        end
    end

    a_r3_awake_core_forces_c0: assert property (@(posedge clk) disable iff (!rst_n)
        chk_awake |=> (pkg_state_o == 3'd0));

    a_r4_no_permission_c0: assert property (@(posedge clk) disable iff (!rst_n)
        !lp_grant_i |=> (pkg_state_o == 3'd0));

    a_r6_c6_needs_all_grants: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && (pkg_state_o == 3'd4) |->
            $past(lp_grant_i && deep_allow_i && deep_grant_i));

    a_r8_cache_tracks_c6: assert property (@(posedge clk) disable iff (!rst_n)
        cache_valid_o == (pkg_state_o != 3'd4));

    a_r9_strobe_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (state_chg_o == (pkg_state_o != $past(pkg_state_o))));
endmodule

// File: tb/pkg_idle_resolver_tb_top.sv
// Self-checking bench: vector table walk, then directed reset and hold tests.
module pkg_idle_resolver_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 4;
    localparam int NV = 15;

    // Vector: {en[3:0], s3, s2, s1, s0, grant, allow, dgrant, expected}
    localparam logic [21:0] VEC [NV] = '{
        {4'b1111, 3'd1, 3'd1, 3'd1, 3'd1, 3'b111, 3'd1},  // R5 uniform C1
        {4'b1111, 3'd3, 3'd2, 3'd4, 3'd3, 3'b111, 3'd2},  // R5 mixed, C1E shallowest
        {4'b1111, 3'd3, 3'd3, 3'd4, 3'd3, 3'b111, 3'd3},  // R5 C3 with C6 mix
        {4'b1111, 3'd4, 3'd4, 3'd4, 3'd4, 3'b111, 3'd4},  // R6 full grants
        {4'b1111, 3'd4, 3'd4, 3'd4, 3'd4, 3'b110, 3'd3},  // R6 allowed, not granted
        {4'b1111, 3'd4, 3'd4, 3'd4, 3'd4, 3'b101, 3'd3},  // R6 granted, not allowed
        {4'b1111, 3'd4, 3'd4, 3'd4, 3'd4, 3'b011, 3'd0},  // R4 no permission
        {4'b1111, 3'd4, 3'd0, 3'd4, 3'd4, 3'b111, 3'd0},  // R3 one awake core
        {4'b0111, 3'd0, 3'd4, 3'd4, 3'd4, 3'b111, 3'd4},  // R7 masked C0 core
        {4'b0000, 3'd0, 3'd0, 3'd0, 3'd0, 3'b111, 3'd4},  // R7 all masked
        {4'b1111, 3'd4, 3'd4, 3'd4, 3'd6, 3'b111, 3'd0},  // R2 unused code
        {4'b1011, 3'd1, 3'd0, 3'd3, 3'd3, 3'b111, 3'd1},  // R7 masked, R5 min
        {4'b1111, 3'd2, 3'd2, 3'd2, 3'd2, 3'b111, 3'd2},  // R5 uniform C1E
        {4'b1111, 3'd2, 3'd2, 3'd2, 3'd2, 3'b111, 3'd2},  // R9 hold, no strobe
        {4'b1111, 3'd3, 3'd3, 3'd3, 3'd3, 3'b011, 3'd0}   // R4 C3 cores, no permission
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NC*3-1:0]   core_state;
    logic [NC-1:0]     core_en;
    logic              lp_grant, deep_allow, deep_grant;
    logic [2:0]        pkg_state;
    logic              cache_valid, state_chg;
    int                checks = 0;
    int                errors = 0;
    logic [2:0]        exp_prev;

    always #(CLK_PERIOD/2) clk = ~clk;

    pkg_idle_resolver #(.NUM_CORES(NC)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .core_state_i  (core_state),
        .core_en_i     (core_en),
        .lp_grant_i    (lp_grant),
        .deep_allow_i  (deep_allow),
        .deep_grant_i  (deep_grant),
        .pkg_state_o   (pkg_state),
        .cache_valid_o (cache_valid),
        .state_chg_o   (state_chg)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_out(input string tag, input logic [2:0] exp);
        check({tag, " state"}, pkg_state, exp);
        check({"R8 cache ", tag}, cache_valid, (exp != 3'd4));
        check({"R9 strobe ", tag}, state_chg, (exp != exp_prev));
        exp_prev = exp;
    endtask

    task automatic drive(input logic [21:0] v);
        core_en    = v[21:18];
        core_state = v[17:6];
        lp_grant   = v[5];
        deep_allow = v[4];
        deep_grant = v[3];
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        drive({4'b1111, 12'h924, 3'b111, 3'd0});
        repeat (3) @(negedge clk);
        check("R1 reset state", pkg_state, 0);
        check("R1 reset cache", cache_valid, 1);
        check("R1 reset strobe", state_chg, 0);
        exp_prev = 3'd0;
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            @(negedge clk);
            check_out($sformatf("R2-R7 vec%0d", i), VEC[i][2:0]);
        end

        // R9: hold a constant C3 request for several cycles.
        drive({4'b1111, 3'd3, 3'd3, 3'd3, 3'd3, 3'b111, 3'd0});
        @(negedge clk);
        check_out("R5 hold start", 3'd3);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check_out("R9 hold", 3'd3);
        end

        // R6 via all cores masked with deep inputs missing, then R1 reset from C6.
        drive({4'b0000, 12'h000, 3'b100, 3'd0});
        @(negedge clk);
        check_out("R7 masked no deep", 3'd3);
        drive({4'b1111, 3'd4, 3'd4, 3'd4, 3'd4, 3'b111, 3'd0});
        @(negedge clk);
        check_out("R6 enter", 3'd4);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset from C6 state", pkg_state, 0);
        check("R1 reset from C6 cache", cache_valid, 1);
        check("R1 reset from C6 strobe", state_chg, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule